// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator with Stereo Gain

The block generates audio from four independent wavetable voices. Each voice has a 24-bit phase accumulator. On every sample tick the accumulator advances by a programmable 16-bit step. The top eight bits of the accumulator index a private 256-entry table of 8-bit waveform samples. The table stores samples in offset binary, so the block flips the top bit to get a two's-complement value. That value is then multiplied by two unsigned 8-bit gains, one for the left channel and one for the right. The four left products are summed into one 18-bit signed sample, and the four right products likewise.

A serial receiver upstream supplies writes as an address byte, a 16-bit data word and a one-cycle strobe. The address picks a function and a voice. The tick is produced internally by dividing the clock, and the block exports it together with the two sample words. A downstream converter uses them to drive pins.

Top module: `wt_synth`

## Requirements
- R1: While reset is held and just after it is released, both output words read zero and every phase accumulator, step and gain reads zero.
- R2: `sample_tick` is high for exactly one clock out of every `TICK_DIV` clocks.
- R3: A write to address 0x00–0x03 (voice = address bits 1:0) loads `wr_data[15:0]` as that voice's step. On every tick the step is added to the 24-bit accumulator, which wraps modulo 2^24 without any other effect.
- R4: A write to address 0x04–0x07 stores the byte `wr_data[7:0]` at table entry `wr_data[15:8]` of the selected voice's table.
- R5: A table byte b contributes the signed value b − 128 (top bit inverted, read as two's complement): 0x00 is −128, 0x80 is 0 and 0xFF is +127.
- R6: Addresses 0x08–0x0B set the left gain and 0x0C–0x0F set the right gain of the selected voice from `wr_data[7:0]`. Each scaled sample is the signed sample times the unsigned gain, so gain 0 gives silence and the two channels are independent.
- R7: Each output word is the 18-bit signed sum of the four voices' scaled samples for its channel. It changes only at the clock edge where `sample_tick` is high and holds its value between ticks.
- R8: A strobe with an address of 0x10 or above has no effect, and neither do address and data presented while `wr_en` is low.
- R9: The output latched at a tick uses each voice's table entry at the accumulator value from before that tick's increment. Hence the first tick after reset reads entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr | input | 8 | Register address from the serial receiver |
| wr_data | input | 16 | Write data from the serial receiver |
| wr_en | input | 1 | One-cycle write strobe |
| sample_tick | output | 1 | One-cycle pulse at the output sample rate |
| out_l | output | 18 | Left summed sample, two's complement |
| out_r | output | 18 | Right summed sample, two's complement |

## Verification
The bench runs a reference model of all four accumulators and tables beside the design and compares both output words at every tick. The table is built so that entry 0 is 0x00 and entry 1 is 0xFF in every voice. With all gains at 255, the first sums therefore sit at the most negative value the mix can reach. A design that skips the top-bit inversion, or that mixes up signed and unsigned in the product, produces wrong magnitudes or wrong signs there. A maximum-step run lasts past one full turn of the accumulator, so a design that saturates or drops carries will lose phase after the wrap. Other checks write to out-of-range addresses, present writes with the strobe low, set channels with zero gain, and watch the outputs between ticks. These catch a design whose decode is too loose, whose channels leak into each other, or whose outputs update off the tick.

// File: rtl/wt_pkg.sv
package wt_pkg;
    parameter int NVOICE    = 4;
    parameter int PHASE_W   = 24;
    parameter int STEP_W    = 16;
    parameter int SAMP_W    = 8;
    parameter int VOL_W     = 8;
    parameter int TBL_DEPTH = 256;
    parameter int ADDR_W    = 8;
    parameter int DATA_W    = 16;

    localparam int IDX_W  = $clog2(TBL_DEPTH);
    localparam int VSEL_W = $clog2(NVOICE);
    localparam int PROD_W = SAMP_W + VOL_W;
    localparam int MIX_W  = PROD_W + $clog2(NVOICE);

    typedef enum logic [1:0] {
        FN_STEP  = 2'd0,
        FN_TABLE = 2'd1,
        FN_GAIN_L = 2'd2,
        FN_GAIN_R = 2'd3
    } fn_e;
endpackage

// File: rtl/wt_tick_gen.sv
module wt_tick_gen #(
    parameter int DIV = 2048
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CNT_W'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R2: the pulse lasts a single cycle
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);
    // R2: divider never leaves its range
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DIV - 1));
endmodule

// File: rtl/wt_voice.sv
module wt_voice
    import wt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     step_we,
    input  logic                     tbl_we,
    input  logic                     gl_we,
    input  logic                     gr_we,
    input  logic [DATA_W-1:0]        wr_data,
    output logic signed [PROD_W-1:0] prod_l,
    output logic signed [PROD_W-1:0] prod_r
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [STEP_W-1:0]  step;
        logic [VOL_W-1:0]   gain_l;
        logic [VOL_W-1:0]   gain_r;
    } vc_state_t;

    vc_state_t st_d, st_q;

    logic [SAMP_W-1:0] wave_mem [TBL_DEPTH];
    logic [SAMP_W-1:0] raw_q;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic signed [SAMP_W-1:0] samp_s;
    logic signed [PROD_W:0]   full_l, full_r;

    always_comb begin
        st_d = st_q;
        if (tick)    st_d.phase  = st_q.phase + PHASE_W'(st_q.step);
        if (step_we) st_d.step   = wr_data[STEP_W-1:0];
        if (gl_we)   st_d.gain_l = wr_data[VOL_W-1:0];
        if (gr_we)   st_d.gain_r = wr_data[VOL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_idx = st_q.phase[PHASE_W-1 -: IDX_W];
    assign wr_idx = wr_data[SAMP_W +: IDX_W];

    // dual-port table: a read colliding with a write returns the old byte
    always_ff @(posedge clk) begin
        if (tbl_we) wave_mem[wr_idx] <= wr_data[SAMP_W-1:0];
        raw_q <= wave_mem[rd_idx];
    end

    always_comb begin
        samp_s = $signed({~raw_q[SAMP_W-1], raw_q[SAMP_W-2:0]});
        full_l = samp_s * $signed({1'b0, st_q.gain_l});
        full_r = samp_s * $signed({1'b0, st_q.gain_r});
        prod_l = full_l[PROD_W-1:0];
        prod_r = full_r[PROD_W-1:0];
    end

    // R3: accumulator moves only on a tick
    p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.phase));
    // R3: step keeps its value without a write
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_we |=> $stable(st_q.step));
    // R6: zero gain silences its channel
    p_mute_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gain_l == '0) |-> (prod_l == '0));
    p_mute_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gain_r == '0) |-> (prod_r == '0));
endmodule

// File: rtl/wt_synth.sv
module wt_synth
    import wt_pkg::*;
#(
    parameter int TICK_DIV = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    wr_en,
    output logic                    sample_tick,
    output logic signed [MIX_W-1:0] out_l,
    output logic signed [MIX_W-1:0] out_r
);
    localparam int FN_LSB = VSEL_W;

    typedef struct packed {
        logic signed [MIX_W-1:0] mix_l;
        logic signed [MIX_W-1:0] mix_r;
    } mx_state_t;

    mx_state_t st_d, st_q;

    logic                    tick;
    logic                    addr_ok;
    fn_e                     fn;
    logic [VSEL_W-1:0]       vsel;
    logic [NVOICE-1:0]       step_we, tbl_we, gl_we, gr_we;
    logic signed [PROD_W-1:0] prod_l [NVOICE];
    logic signed [PROD_W-1:0] prod_r [NVOICE];

    wt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        addr_ok = wr_en && (wr_addr[ADDR_W-1:FN_LSB+2] == '0);
        fn      = fn_e'(wr_addr[FN_LSB +: 2]);
        vsel    = wr_addr[VSEL_W-1:0];
        step_we = '0;
        tbl_we  = '0;
        gl_we   = '0;
        gr_we   = '0;
        if (addr_ok) begin
            unique case (fn)
                FN_STEP:   step_we[vsel] = 1'b1;
                FN_TABLE:  tbl_we[vsel]  = 1'b1;
                FN_GAIN_L: gl_we[vsel]   = 1'b1;
                FN_GAIN_R: gr_we[vsel]   = 1'b1;
            endcase
        end
    end

    for (genvar v = 0; v < NVOICE; v++) begin : g_voice
        wt_voice u_voice (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .step_we(step_we[v]),
            .tbl_we (tbl_we[v]),
            .gl_we  (gl_we[v]),
            .gr_we  (gr_we[v]),
            .wr_data(wr_data),
            .prod_l (prod_l[v]),
            .prod_r (prod_r[v])
        );
    end

    always_comb begin
        logic signed [MIX_W-1:0] acc_l, acc_r;
        acc_l = '0;
        acc_r = '0;
        for (int v = 0; v < NVOICE; v++) begin
            acc_l = acc_l + MIX_W'(prod_l[v]);
            acc_r = acc_r + MIX_W'(prod_r[v]);
        end
        st_d = st_q;
        if (tick) begin
            st_d.mix_l = acc_l;
            st_d.mix_r = acc_r;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_tick = tick;
    assign out_l       = st_q.mix_l;
    assign out_r       = st_q.mix_r;

    // R8: rejected writes reach no voice register
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_addr[ADDR_W-1:FN_LSB+2] != '0))
            |-> ({step_we, tbl_we, gl_we, gr_we} == '0));
    // R4: at most one register written per strobe
    p_onehot_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_we, tbl_we, gl_we, gr_we}));
    // R7: outputs held between ticks
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(out_l) && $stable(out_r)));
    // R7: sum stays within the reachable range
    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_l >= -(NVOICE * 128 * 255)) && (out_l <= NVOICE * 127 * 255)
        && (out_r >= -(NVOICE * 128 * 255)) && (out_r <= NVOICE * 127 * 255));
endmodule

// File: tb/wt_synth_bench.sv
module wt_synth_bench;
    localparam int DIV = 32;
    localparam int NV  = 4;
    localparam int NVEC = 8;

    localparam logic [15:0] V_STEP [NVEC][NV] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0100, 16'h0400, 16'h1000, 16'h4000},
        '{16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF},
        '{16'h1234, 16'hABCD, 16'h0F0F, 16'hF0F0},
        '{16'h2000, 16'h2000, 16'h2000, 16'h2000},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0800, 16'h0000, 16'h0800, 16'h0000}
    };
    localparam logic [7:0] V_GL [NVEC][NV] = '{
        '{8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd10,  8'd20,  8'd30,  8'd40},
        '{8'd255, 8'd0,   8'd255, 8'd0},
        '{8'd1,   8'd2,   8'd3,   8'd4},
        '{8'd128, 8'd128, 8'd128, 8'd128},
        '{8'd99,  8'd1,   8'd0,   8'd77},
        '{8'd255, 8'd255, 8'd255, 8'd255}
    };
    localparam logic [7:0] V_GR [NVEC][NV] = '{
        '{8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd128, 8'd64,  8'd1,   8'd255},
        '{8'd40,  8'd30,  8'd20,  8'd10},
        '{8'd0,   8'd255, 8'd0,   8'd255},
        '{8'd200, 8'd150, 8'd100, 8'd50},
        '{8'd127, 8'd127, 8'd127, 8'd127},
        '{8'd5,   8'd6,   8'd7,   8'd8},
        '{8'd255, 8'd255, 8'd255, 8'd255}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         wr_addr = '0;
    logic [15:0]        wr_data = '0;
    logic               wr_en = 1'b0;
    logic               sample_tick;
    logic signed [17:0] out_l, out_r;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_tbl  [NV][256];
    logic [23:0] m_phase [NV];
    logic [15:0] m_step [NV];
    logic [7:0]  m_gl   [NV];
    logic [7:0]  m_gr   [NV];

    wt_synth #(.TICK_DIV(DIV)) u_wt_synth (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .sample_tick(sample_tick),
        .out_l      (out_l),
        .out_r      (out_r)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int model_sum(input bit left);
        int s = 0;
        for (int v = 0; v < NV; v++) begin
            int smp = int'(m_tbl[v][m_phase[v][23:16]]) - 128;
            s += smp * int'(left ? m_gl[v] : m_gr[v]);
        end
        return s;
    endfunction

    // wait for a tick, check both sums (R5 R6 R7 R9), advance model phase (R3)
    task automatic tick_check(input string tag);
        int el, er;
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        el = model_sum(1'b1);
        er = model_sum(1'b0);
        @(negedge clk);
        check({tag, " R5 R6 R7 R9 left"}, int'(out_l), el);
        check({tag, " R5 R6 R7 R9 right"}, int'(out_r), er);
        for (int v = 0; v < NV; v++) m_phase[v] = m_phase[v] + 24'(m_step[v]);
    endtask

    task automatic set_regs(input int k);
        for (int v = 0; v < NV; v++) begin
            wr(8'(v), V_STEP[k][v]);       m_step[v] = V_STEP[k][v];
            wr(8'(8 + v), 16'(V_GL[k][v])); m_gl[v] = V_GL[k][v];
            wr(8'(12 + v), 16'(V_GR[k][v])); m_gr[v] = V_GR[k][v];
        end
    endtask

    initial begin
        int gap;
        for (int v = 0; v < NV; v++) begin
            m_phase[v] = '0; m_step[v] = '0; m_gl[v] = '0; m_gr[v] = '0;
            for (int i = 0; i < 256; i++)
                m_tbl[v][i] = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF
                            : 8'((i * 29 + v * 71 + 5) & 8'hFF);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_l in reset", int'(out_l), 0);
        check("R1 out_r in reset", int'(out_r), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_l after release", int'(out_l), 0);
        check("R1 tick low after release", int'(sample_tick), 0);

        // R2: tick period and width
        while (!sample_tick) @(negedge clk);
        @(negedge clk);
        check("R2 tick width", int'(sample_tick), 0);
        gap = 1;
        while (!sample_tick) begin @(negedge clk); gap++; end
        check("R2 tick period", gap, DIV);

        // R4: load every table (steps are zero so phases stay at 0)
        for (int v = 0; v < NV; v++)
            for (int i = 0; i < 256; i++)
                wr(8'(4 + v), {8'(i), m_tbl[v][i]});
        @(negedge clk);
        check("R1 out_l zero gains", int'(out_l), 0);

        // R8: gains 255 written through illegal addresses or with strobe low
        wr(8'h18, 16'h00FF);
        wr(8'h48, 16'h00FF);
        wr(8'hFC, 16'h00FF);
        wr_addr = 8'h0C; wr_data = 16'h00FF;
        repeat (3) @(negedge clk);
        tick_check("R8 ignored writes");
        tick_check("R8 ignored writes");

        // vector table walk
        for (int k = 0; k < NVEC; k++) begin
            set_regs(k);
            for (int t = 0; t < 4; t++) tick_check($sformatf("R3 vec%0d", k));
        end

        // R7: outputs hold between ticks
        begin
            int hl, hr;
            hl = int'(out_l); hr = int'(out_r);
            repeat (DIV / 2) @(negedge clk);
            check("R7 hold left", int'(out_l), hl);
            check("R7 hold right", int'(out_r), hr);
        end

        // R3: maximum step across a full accumulator turn
        for (int v = 0; v < NV; v++) begin
            wr(8'(v), 16'hFFFF); m_step[v] = 16'hFFFF;
            wr(8'(8 + v), 16'(v * 60 + 15)); m_gl[v] = 8'(v * 60 + 15);
        end
        for (int t = 0; t < 300; t++) tick_check("R3 wrap");

        // R6: channel independence, left muted
        for (int v = 0; v < NV; v++) begin
            wr(8'(8 + v), 16'h0000); m_gl[v] = '0;
        end
        tick_check("R6 left muted");
        check("R6 left silent", int'(out_l), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule